// File: doc/BRIEF.md
# Iterative Wide Multiply-Divide Unit

This unit computes one long arithmetic operation at a time: an unsigned W x W multiply to a 2W-bit product, an unsigned 2W / W divide to a W-bit quotient and remainder, or a signed W / (W/2) divide to a signed quotient and remainder that fit in W/2 bits. The multiply adds and shifts once per cycle. The unsigned divide uses restoring shift-subtract, once per cycle. The signed divide runs the same unsigned core on operand magnitudes and then corrects the signs. A single status flag reports divide-by-zero and every kind of quotient overflow.

Control is a plain start/busy/done handshake, so the input side works as valid/ready with ready equal to `!busy`. A caller holds `start` and the operands until a cycle in which `busy` is low. That cycle accepts the request. A `start` raised while `busy` is high is ignored and does not queue. The output side has no back-pressure. `done` pulses for exactly one cycle, and the result and flag stay unchanged until a later request finishes. A caller that misses the pulse can read the held values at any time before its next accepted start.

Top module: `wide_muldiv`

## Requirements
- R1: A start is accepted only on a rising edge at which `busy` is low. `busy` is high from the next cycle until the cycle that shows `done`. A `start` raised while `busy` is high has no effect.
- R2: `op` selects the operation: 2'b00 unsigned multiply, 2'b01 unsigned divide, 2'b10 signed divide. The code 2'b11 is reserved and ends with `fault`=1 and zero results, two cycles after acceptance.
- R3: Multiply: {`res_hi`,`res_lo`} is the unsigned product `a_in` x `b_in` and `fault` is 0, including all-ones operands.
- R4: Unsigned divide: the dividend is {`a_in`,`c_in`} and the divisor is `b_in`. `res_lo` is the quotient and `res_hi` is the remainder. This holds for divisors whose top bit is set.
- R5: Unsigned divide with `a_in` >= `b_in` (this includes `b_in`=0) does not iterate. It ends two cycles after acceptance with `fault`=1 and both results zero. On every completion with a fault, both results are zero.
- R6: Signed divide: the dividend is `a_in` (two's complement, W bits) and the divisor is `b_in[W/2-1:0]` (two's complement). The quotient rounds toward zero, and the remainder has the sign of the dividend. Both are sign-extended to W bits, with the quotient in `res_lo` and the remainder in `res_hi`.
- R7: Signed divide with a zero divisor does not iterate. It ends two cycles after acceptance with `fault`=1 and zero results.
- R8: Signed divide whose true quotient lies outside -2^(W/2-1) .. 2^(W/2-1)-1 ends after the full run with `fault`=1 and zero results. Both limits themselves are valid quotients.
- R9: Every operation not rejected early shows `done` exactly W+2 cycles after the accepting edge. `done` lasts one cycle, and `busy` is low while it shows.
- R10: `res_hi`, `res_lo` and `fault` change only in the cycle in which `done` rises. They hold between completions.
- R11: After reset, `busy`, `done`, `fault`, `res_hi` and `res_lo` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted when busy is low |
| op | input | 2 | Operation code (see R2) |
| a_in | input | W | Multiplicand, high dividend half, or signed dividend |
| b_in | input | W | Multiplier, unsigned divisor, or signed divisor in the low W/2 bits |
| c_in | input | W | Low dividend half for the unsigned divide |
| busy | output | 1 | Operation in progress; ready is its inverse |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Divide-by-zero or overflow flag of the last completion |
| res_hi | output | W | Product high half, or remainder |
| res_lo | output | W | Product low half, or quotient |

## Verification
Two things can happen in the same cycle: a completion, where `done` shows and the results update, and the acceptance of the next request, because `busy` is already low while `done` shows. The bench issues requests back to back. Each new start lands in the completion cycle of the previous one. The scoreboard then checks two things: the finished result against its queued expectation, and the new request's latency counted from that shared cycle. A separate case raises `start` in the middle of a run. It then confirms that only one completion arrives, with the first request's values, and that `busy` falls afterwards.

// File: rtl/wide_muldiv_pkg.sv
package wide_muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_DIVU = 2'b01,
    OP_DIVS = 2'b10,
    OP_RSV  = 2'b11
  } wmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } wmd_state_e;
endpackage

// File: rtl/wmd_mul_step.sv
module wmd_mul_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic [W:0] sum;

  // low half holds the remaining multiplier bits; its LSB gates the add
  always_comb begin
    sum    = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
    nxt_hi = sum[W:1];
    nxt_lo = {sum[0], acc_lo[W-1:1]};
  end
endmodule

// File: rtl/wmd_div_step.sv
module wmd_div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_hi,
  input  logic [W-1:0] quo_lo,
  input  logic [W-1:0] dvsr,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic         spill;
  logic [W-1:0] shifted;
  logic         take;

  // spill is the bit leaving the partial remainder; if set, the true
  // value exceeds any W-bit divisor, and the wrapped subtract is exact
  always_comb begin
    spill   = rem_hi[W-1];
    shifted = {rem_hi[W-2:0], quo_lo[W-1]};
    take    = spill || (shifted >= dvsr);
    nxt_hi  = take ? (shifted - dvsr) : shifted;
    nxt_lo  = {quo_lo[W-2:0], take};
  end
endmodule

// File: rtl/wmd_sign_fix.sv
module wmd_sign_fix #(
  parameter int W  = 64,
  parameter int HW = 32
) (
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  input  logic         q_neg,
  input  logic         r_neg,
  output logic [W-1:0] q_out,
  output logic [W-1:0] r_out,
  output logic         range_err
);
  localparam logic [W-1:0] POS_LIM = {{(W-HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = POS_LIM + W'(1);

  always_comb begin
    range_err = q_neg ? (q_mag > NEG_LIM) : (q_mag > POS_LIM);
    q_out     = q_neg ? (~q_mag + W'(1)) : q_mag;
    r_out     = r_neg ? (~r_mag + W'(1)) : r_mag;
  end
endmodule

// File: rtl/wide_muldiv.sv
module wide_muldiv
  import wide_muldiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] c_in,
  output logic         busy,
  output logic         done,
  output logic         fault,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int HW   = W / 2;
  localparam int CNTW = $clog2(W);
  localparam logic [CNTW-1:0] LAST_STEP = CNTW'(W - 1);

  wmd_state_e      state;
  wmd_op_e         op_q;
  logic [CNTW-1:0] step;
  logic [W-1:0]    hi_q, lo_q, aux_q;
  logic            qneg_q, rneg_q, early_q;

  wmd_op_e         op_in;
  logic [HW-1:0]   sdiv;
  logic [HW-1:0]   sdiv_mag;
  logic [W-1:0]    sdend_mag;
  logic [W-1:0]    mul_hi, mul_lo, div_hi, div_lo;
  logic [W-1:0]    fix_q, fix_r;
  logic            fix_err;

  assign op_in     = wmd_op_e'(op);
  assign sdiv      = b_in[HW-1:0];
  assign sdiv_mag  = sdiv[HW-1] ? (~sdiv + HW'(1)) : sdiv;
  assign sdend_mag = a_in[W-1] ? (~a_in + W'(1)) : a_in;
  assign busy      = (state != ST_IDLE);

  wmd_mul_step #(.W(W)) u_mul (
    .acc_hi(hi_q), .acc_lo(lo_q), .mcand(aux_q),
    .nxt_hi(mul_hi), .nxt_lo(mul_lo)
  );

  wmd_div_step #(.W(W)) u_div (
    .rem_hi(hi_q), .quo_lo(lo_q), .dvsr(aux_q),
    .nxt_hi(div_hi), .nxt_lo(div_lo)
  );

  wmd_sign_fix #(.W(W), .HW(HW)) u_fix (
    .q_mag(lo_q), .r_mag(hi_q), .q_neg(qneg_q), .r_neg(rneg_q),
    .q_out(fix_q), .r_out(fix_r), .range_err(fix_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_MULU;
      step    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      aux_q   <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      early_q <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op_in;
            step    <= '0;
            early_q <= 1'b0;
            qneg_q  <= 1'b0;
            rneg_q  <= 1'b0;
            state   <= ST_RUN;
            unique case (op_in)
              OP_MULU: begin
                hi_q  <= '0;
                lo_q  <= b_in;
                aux_q <= a_in;
              end
              OP_DIVU: begin
                hi_q  <= a_in;
                lo_q  <= c_in;
                aux_q <= b_in;
                if (a_in >= b_in) begin
                  early_q <= 1'b1;
                  state   <= ST_FIN;
                end
              end
              OP_DIVS: begin
                hi_q   <= '0;
                lo_q   <= sdend_mag;
                aux_q  <= {{(W-HW){1'b0}}, sdiv_mag};
                qneg_q <= a_in[W-1] ^ sdiv[HW-1];
                rneg_q <= a_in[W-1];
                if (sdiv == '0) begin
                  early_q <= 1'b1;
                  state   <= ST_FIN;
                end
              end
              default: begin
                early_q <= 1'b1;
                state   <= ST_FIN;
              end
            endcase
          end
        end
        ST_RUN: begin
          if (op_q == OP_MULU) begin
            hi_q <= mul_hi;
            lo_q <= mul_lo;
          end else begin
            hi_q <= div_hi;
            lo_q <= div_lo;
          end
          step <= step + CNTW'(1);
          if (step == LAST_STEP) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (early_q || (op_q == OP_DIVS && fix_err)) begin
            fault  <= 1'b1;
            res_hi <= '0;
            res_lo <= '0;
          end else if (op_q == OP_DIVS) begin
            fault  <= 1'b0;
            res_hi <= fix_r;
            res_lo <= fix_q;
          end else begin
            fault  <= 1'b0;
            res_hi <= hi_q;
            res_lo <= lo_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wide_muldiv_chk.sv
module wide_muldiv_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo
);
  localparam int HW = W / 2;

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1

  AST_RSV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'b11) |=> ##1 (done && fault)); // R2

  AST_DIVU_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'b01 && a_in >= b_in) |=> ##1 (done && fault)); // R5

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (res_hi == '0 && res_lo == '0)); // R5

  AST_DIVS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'b10 && b_in[HW-1:0] == '0) |=> ##1 (done && fault)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_hi) && $stable(res_lo) && $stable(fault))); // R10
endmodule

bind wide_muldiv wide_muldiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a_in(a_in),
  .b_in(b_in), .busy(busy), .done(done), .fault(fault),
  .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/tb_wide_muldiv.sv
module tb_wide_muldiv;
  localparam int W      = 64;
  localparam int LAT    = W + 2;
  localparam int LAT_EF = 2;

  typedef struct {
    logic [63:0] hi;
    logic [63:0] lo;
    logic        flt;
    int          lat;
    int          scyc;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [63:0] a_i = '0, b_i = '0, c_i = '0;
  logic        busy, done, fault;
  logic [63:0] res_hi, res_lo;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  item_t sbq[$];
  item_t last;

  always #4 clk = ~clk; // 125 MHz

  wide_muldiv #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .a_in(a_i),
    .b_in(b_i), .c_in(c_i), .busy(busy), .done(done), .fault(fault),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each completion with the front of the scoreboard
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R1 unexpected done", {res_hi, res_lo}, '0);
      end else begin
        item_t it;
        it   = sbq.pop_front();
        last = it;
        chk({res_hi, res_lo} === {it.hi, it.lo}, it.req, {res_hi, res_lo}, {it.hi, it.lo});
        chk(fault === it.flt, {it.req, " fault"}, 128'(fault), 128'(it.flt));
        chk((cyc - it.scyc) == it.lat, {it.req, " R9 latency"},
            128'(cyc - it.scyc), 128'(it.lat));
        chk(busy === 1'b0, "R9 busy low at done", 128'(busy), 128'(0));
      end
    end
  end

  task automatic apply(input logic [1:0] o, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] c, input string req);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.req = req;
    it.flt = 1'b0;
    it.lat = LAT;
    case (o)
      2'b00: {it.hi, it.lo} = {64'b0, a} * {64'b0, b};
      2'b01: begin
        if (a >= b) begin
          it.flt = 1'b1; it.hi = '0; it.lo = '0; it.lat = LAT_EF;
        end else begin
          logic [127:0] n, q, r;
          n = {a, c};
          q = n / {64'b0, b};
          r = n % {64'b0, b};
          it.lo = q[63:0];
          it.hi = r[63:0];
        end
      end
      2'b10: begin
        if (b[31:0] == 32'd0) begin
          it.flt = 1'b1; it.hi = '0; it.lo = '0; it.lat = LAT_EF;
        end else begin
          logic signed [127:0] dn, dv, q, r;
          dn = {{64{a[63]}}, a};
          dv = {{96{b[31]}}, b[31:0]};
          q  = dn / dv;
          r  = dn % dv;
          if (q > 128'sd2147483647 || q < -128'sd2147483648) begin
            it.flt = 1'b1; it.hi = '0; it.lo = '0;
          end else begin
            it.lo = q[63:0];
            it.hi = r[63:0];
          end
        end
      end
      default: begin
        it.flt = 1'b1; it.hi = '0; it.lo = '0; it.lat = LAT_EF;
      end
    endcase
    it.scyc = cyc;
    op_i = o; a_i = a; b_i = b; c_i = c;
    start = 1'b1;
    sbq.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1 busy after accept", 128'(busy), 128'(1));
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, fault} === 3'b000, "R11 control at reset", 128'({busy, done, fault}), '0);
    chk({res_hi, res_lo} === '0, "R11 results at reset", {res_hi, res_lo}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done} === 2'b00, "R11 idle after reset", 128'({busy, done}), '0);

    // back-to-back: each start lands in the previous done cycle
    apply(2'b00, 64'd12345, 64'd678910, 64'd0, "R3 small mul");
    apply(2'b00, '1, '1, 64'd0, "R3 max mul");
    apply(2'b00, 64'h8000_0000_0000_0001, 64'd0, 64'd0, "R3 zero mul");
    apply(2'b00, 64'hDEAD_BEEF_0123_4567, 64'hFEDC_BA98_7654_3210, 64'd0, "R3 mixed mul");
    apply(2'b01, 64'd5, 64'd7, 64'h1234_5678_9ABC_DEF0, "R4 divu");
    apply(2'b01, 64'hFFFF_FFFF_FFFF_FFEF, 64'hFFFF_FFFF_FFFF_FFF0, '1, "R4 divu wide divisor");
    apply(2'b01, 64'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_0000_0001, "R4 divu top-bit divisor");
    apply(2'b01, 64'd9, 64'd9, 64'd1, "R5 divu overflow equal");
    apply(2'b01, 64'd0, 64'd0, 64'd4, "R5 divu by zero");
    apply(2'b10, 64'd100, 64'd7, 64'd0, "R6 divs pos/pos");
    apply(2'b10, -64'sd7, 64'd2, 64'd0, "R6 divs neg/pos");
    apply(2'b10, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, "R6 divs pos/neg");
    apply(2'b10, -64'sd1000001, 64'h0000_0000_FFFF_FFF6, 64'd0, "R6 divs neg/neg");
    apply(2'b10, -64'sd2147483648, 64'd1, 64'd0, "R8 divs low limit ok");
    apply(2'b10, 64'd2147483647, 64'd1, 64'd0, "R8 divs high limit ok");
    apply(2'b10, 64'd2147483648, 64'd1, 64'd0, "R8 divs overflow high");
    apply(2'b10, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF, 64'd0, "R8 divs overflow min/-1");
    apply(2'b10, 64'd55, 64'hFFFF_FFFF_0000_0000, 64'd0, "R7 divs zero divisor");
    apply(2'b11, 64'd3, 64'd4, 64'd5, "R2 reserved op");
    apply(2'b00, 64'd3, 64'd5, 64'd0, "R2 op 00 after reserved");
    drain();

    // hold: outputs must stay at the last result with no new start
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk({res_hi, res_lo, fault} === {last.hi, last.lo, last.flt}, "R10 hold",
          {res_hi, res_lo}, {last.hi, last.lo});
    end

    // start raised mid-run must be ignored
    apply(2'b00, 64'd1000, 64'd3, 64'd0, "R1 run before ignored start");
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R1 busy mid-run", 128'(busy), 128'(1));
    op_i = 2'b01; a_i = 64'd100; b_i = 64'd3; c_i = 64'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 ignored start left idle", 128'(busy), 128'(0));
    chk({res_hi, res_lo} === {64'd0, 64'd3000}, "R1 result of first request",
        {res_hi, res_lo}, {64'd0, 64'd3000});

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule